// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word-addressed memory. It serves several requesters; the default is two. Each requester sends requests over its own valid/ready channel. A request is an ordinary load, an ordinary store, a linking load, or a conditional store. A linking load returns the addressed word. It also records a reservation for that requester, made of a valid flag and the linked address. A conditional store writes only when that requester still holds a valid reservation for the same address. It answers 1 when the write happens and 0 when it does not. A write to a reserved word clears the reservation on that word, whichever requester makes the write.

The memory has a single port, so the block accepts at most one request per cycle. A fixed priority decides between requesters: a lower index wins. A requester that loses is held off by a low ready and must keep its request stable until it is accepted. Responses come back exactly one cycle after acceptance, as a one-cycle pulse on that requester's response channel. The response channel has no back-pressure: the requester must take the response in the cycle it is presented. Software builds atomic read-modify-write on this block with a retry loop: issue a linking load, compute, issue a conditional store, and repeat when the store fails.

Top module: `llsc_monitor`

## Requirements
- R1: At most one request is accepted per cycle. Requester 0 is always ready. Requester i is ready only in a cycle where no requester with a lower index has valid high. Ready depends on nothing else.
- R2: A request is accepted on a clock edge where its valid and ready are both high. Exactly one cycle later, that requester's response valid is high for one cycle. No other requester's response valid is high in that cycle.
- R3: Request codes on req_op are 00 load, 01 store, 10 linking load, 11 conditional store. A load returns the word as left by all earlier accepted requests. A store writes req_wdata to the word.
- R4: A linking load returns the word. It sets that requester's reservation to valid with its address, and this replaces any earlier reservation of the same requester.
- R5: A conditional store whose requester holds a valid reservation for the same address writes the word and responds 1.
- R6: A conditional store without a valid reservation, or with a reservation for a different address, responds 0 and leaves memory unchanged.
- R7: Every memory write clears all valid reservations on the written address. This holds for a store from any requester, including the reservation holder itself, and for a successful conditional store. A write to another address leaves a reservation intact.
- R8: Every accepted conditional store clears its own requester's reservation, whatever its outcome.
- R9: The response data of a store is 0. For a conditional store, the result is in bit 0 and all upper bits are 0. On a response channel whose valid is low, the data is 0.
- R10: After reset, every memory word is 0, no reservation is valid and no response valid is high.
- R11: When two requesters each run a linking-load / conditional-store increment loop on one word, no increment is lost. The final value equals the start value plus the total number of successful conditional stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_ready | output | NREQ | Request ready, one bit per requester |
| req_op | input | 2*NREQ | Request code per requester, requester i at bits [2i+1:2i] |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data per requester |
| rsp_valid | output | NREQ | One-cycle response pulse per requester |
| rsp_rdata | output | DW*NREQ | Response data per requester (read word, 0, or success bit) |

## Verification
The bench builds the monitor with two requesters, a 3-bit address (eight words) and a 16-bit word. With only eight words, random traffic from both requesters keeps landing on reserved addresses. Collisions between linking loads, stores and conditional stores therefore happen often, not rarely. The narrow word keeps the increment loop's expected totals easy to follow. Two requesters are the smallest setup that exercises priority stalls and reservations broken by another requester.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int NREQ = 2
) (
  input  logic [NREQ-1:0] valid,
  output logic [NREQ-1:0] ready,
  output logic [NREQ-1:0] grant
);

  // Fixed priority: lower index wins; ready is independent of own valid.
  assign ready[0] = 1'b1;

  generate
    for (genvar i = 1; i < NREQ; i++) begin : g_rdy
      assign ready[i] = ~|valid[i-1:0];
    end
  endgenerate

  assign grant = valid & ready;

endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_set,
  input  logic          cond_done,
  input  logic          wr_en,
  input  logic [AW-1:0] acc_addr,
  output logic          resv_vld,
  output logic [AW-1:0] resv_addr
);

  logic wr_hit;

  assign wr_hit = wr_en && resv_vld && (resv_addr == acc_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_vld  <= 1'b0;
      resv_addr <= '0;
    end else if (link_set) begin
      resv_vld  <= 1'b1;
      resv_addr <= acc_addr;
    end else if (cond_done || wr_hit) begin
      resv_vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/llsc_ram.sv
module llsc_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  output logic [NREQ-1:0]    req_ready,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [DW*NREQ-1:0] rsp_rdata
);

  import llsc_pkg::*;

  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0] grant;
  logic            fire;
  logic [IW-1:0]   gidx;
  llsc_op_e        sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wdata;
  logic [NREQ-1:0] resv_vld;
  logic [AW-1:0]   resv_addr [NREQ];
  logic            cond_ok;
  logic            mem_we;
  logic [DW-1:0]   ram_rdata;
  logic [DW-1:0]   rsp_next;
  logic [DW-1:0]   rsp_data_q;
  logic [NREQ-1:0] rsp_vld_q;

  llsc_arbiter #(.NREQ(NREQ)) u_arb (
    .valid (req_valid),
    .ready (req_ready),
    .grant (grant)
  );

  assign fire = |grant;

  always_comb begin
    gidx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (grant[i]) gidx = IW'(i);
    end
  end

  assign sel_op    = llsc_op_e'(req_op[2*gidx +: 2]);
  assign sel_addr  = req_addr[AW*gidx +: AW];
  assign sel_wdata = req_wdata[DW*gidx +: DW];

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_resv
      llsc_resv_unit #(.AW(AW)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_set  (grant[i] && (sel_op == OP_LINK)),
        .cond_done (grant[i] && (sel_op == OP_COND)),
        .wr_en     (mem_we),
        .acc_addr  (sel_addr),
        .resv_vld  (resv_vld[i]),
        .resv_addr (resv_addr[i])
      );
    end
  endgenerate

  assign cond_ok = resv_vld[gidx] && (resv_addr[gidx] == sel_addr);
  assign mem_we  = fire && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && cond_ok));

  llsc_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    unique case (sel_op)
      OP_LOAD, OP_LINK: rsp_next = ram_rdata;
      OP_COND:          rsp_next = DW'(cond_ok);
      default:          rsp_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q  <= '0;
      rsp_data_q <= '0;
    end else begin
      rsp_vld_q <= grant;
      if (fire) rsp_data_q <= rsp_next;
    end
  end

  assign rsp_valid = rsp_vld_q;

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_rsp
      assign rsp_rdata[DW*i +: DW] = rsp_vld_q[i] ? rsp_data_q : '0;
    end
  endgenerate

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREQ-1:0]    req_valid,
  input logic [NREQ-1:0]    req_ready,
  input logic [2*NREQ-1:0]  req_op,
  input logic [NREQ-1:0]    rsp_valid,
  input logic [DW*NREQ-1:0] rsp_rdata,
  input logic [NREQ-1:0]    resv_vld
);

  logic [NREQ-1:0] acc;
  assign acc = req_valid & req_ready;

  // R1
  single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc));

  // R2
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_chk
      // R2
      rsp_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc[i] |=> rsp_valid[i]);
      // R2
      no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc[i] |=> !rsp_valid[i]);
      // R4
      link_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[i] && req_op[2*i +: 2] == 2'b10) |=> resv_vld[i]);
      // R8
      cond_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[i] && req_op[2*i +: 2] == 2'b11) |=> !resv_vld[i]);
      // R9
      cond_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[i] && req_op[2*i +: 2] == 2'b11) |=> (rsp_rdata[DW*i+1 +: DW-1] == '0));
      // R6
      norsv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[i] && req_op[2*i +: 2] == 2'b11 && !resv_vld[i]) |=> (rsp_rdata[DW*i +: DW] == '0));
    end
  endgenerate

endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .resv_vld  (resv_vld)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  localparam int NREQ  = 2;
  localparam int AW    = 3;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NINC  = 20;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NREQ-1:0]    req_valid;
  logic [NREQ-1:0]    req_ready;
  logic [2*NREQ-1:0]  req_op;
  logic [AW*NREQ-1:0] req_addr;
  logic [DW*NREQ-1:0] req_wdata;
  logic [NREQ-1:0]    rsp_valid;
  logic [DW*NREQ-1:0] rsp_rdata;

  logic [1:0]    cv;
  logic [1:0]    cop [2];
  logic [AW-1:0] cad [2];
  logic [DW-1:0] cwd [2];

  logic [DW-1:0] mm [DEPTH];
  logic          mv [2];
  logic [AW-1:0] ma [2];

  int            nvec = 0, nerr = 0;
  int            last_g;
  logic [DW-1:0] last_d;
  bit            done = 0;

  always #10 clk = ~clk;

  assign req_valid = cv;
  assign req_op    = {cop[1], cop[0]};
  assign req_addr  = {cad[1], cad[0]};
  assign req_wdata = {cwd[1], cwd[0]};

  llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_llsc_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mwrite(logic [AW-1:0] a, logic [DW-1:0] w);
    mm[a] = w;
    for (int j = 0; j < 2; j++) if (mv[j] && ma[j] == a) mv[j] = 1'b0;
  endtask

  task automatic model(int g, output logic [DW-1:0] d);
    logic ok;
    case (cop[g])
      LD: d = mm[cad[g]];
      ST: begin d = '0; mwrite(cad[g], cwd[g]); end
      LL: begin d = mm[cad[g]]; mv[g] = 1'b1; ma[g] = cad[g]; end
      default: begin
        ok = mv[g] && (ma[g] == cad[g]);
        mv[g] = 1'b0;
        if (ok) mwrite(cad[g], cwd[g]);
        d = DW'(ok);
      end
    endcase
  endtask

  // Called at a falling edge with inputs already set.
  task automatic step(string tag);
    int g;
    logic [DW-1:0] ed;
    ed = '0;
    #1;
    chk("R1 ready0", DW'(req_ready[0]), DW'(1'b1));
    chk("R1 ready1", DW'(req_ready[1]), DW'(!cv[0]));
    g = cv[0] ? 0 : (cv[1] ? 1 : -1);
    if (g >= 0) model(g, ed);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk({tag, " R2 rsp_valid"}, DW'(rsp_valid[i]), DW'(i == g));
      chk({tag, " R9 data"}, rsp_rdata[DW*i +: DW], (i == g) ? ed : '0);
    end
    last_g = g;
    last_d = (g >= 0) ? rsp_rdata[DW*g +: DW] : '0;
  endtask

  task automatic one(int i, logic [1:0] op, int a, int w, string tag);
    cv = '0;
    cv[i] = 1'b1; cop[i] = op; cad[i] = AW'(a); cwd[i] = DW'(w);
    step(tag);
    cv = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int st [2];
    int gap [2];
    int cnt [2];
    logic [DW-1:0] sv [2];
    bit pend [2];
    logic [DW-1:0] start;
    int guard;
    void'($urandom(32'd20240611));
    cv = '0;
    for (int i = 0; i < 2; i++) begin
      cop[i] = LD; cad[i] = '0; cwd[i] = '0; mv[i] = 1'b0; ma[i] = '0;
    end
    for (int k = 0; k < DEPTH; k++) mm[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 rsp_valid after reset", DW'(rsp_valid), '0);

    // R10: memory zero, no reservation
    for (int k = 0; k < DEPTH; k++) one(k % 2, LD, k, 0, "R10 zero word");
    one(1, SC, 0, 5, "R10 no reservation");
    one(1, LD, 0, 0, "R10 word untouched");

    // R4 R5 basic link then conditional
    one(0, LL, 2, 0, "R4 link");
    one(0, SC, 2, 7, "R5 success");
    one(0, LD, 2, 0, "R5 written");
    // R8: reservation consumed
    one(0, SC, 2, 9, "R8 second cond fails");
    one(0, LD, 2, 0, "R8 word kept");
    // R7: other requester store breaks link
    one(0, LL, 2, 0, "R7 link");
    one(1, ST, 2, 16'h0009, "R7 foreign store");
    one(0, SC, 2, 11, "R7 cond fails");
    one(0, LD, 2, 0, "R7 word is store value");
    // R6: mismatched address
    one(0, LL, 4, 0, "R6 link");
    one(0, SC, 5, 3, "R6 other address fails");
    one(0, LD, 5, 0, "R6 word unchanged");
    // R4: replacement
    one(0, LL, 6, 0, "R4 link a");
    one(0, LL, 7, 0, "R4 link b");
    one(0, SC, 6, 1, "R4 old link gone");
    one(0, LL, 6, 0, "R4 link a again");
    one(0, LL, 7, 0, "R4 link b again");
    one(0, SC, 7, 2, "R4 new link holds");
    // R7: own store clears
    one(1, LL, 1, 0, "R7 own link");
    one(1, ST, 1, 3, "R7 own store");
    one(1, SC, 1, 4, "R7 own cond fails");
    // R7: unrelated write keeps link
    one(0, LL, 3, 0, "R7 keep link");
    one(1, ST, 5, 8, "R7 unrelated store");
    one(0, SC, 3, 12, "R7 cond succeeds");
    // R1: simultaneous requests
    cv = 2'b11;
    cop[0] = LD; cad[0] = 3'd3; cwd[0] = '0;
    cop[1] = ST; cad[1] = 3'd3; cwd[1] = 16'h00aa;
    step("R1 both valid, req0 first");
    cv = 2'b10;
    step("R1 req1 after stall");
    cv = '0;
    one(0, LD, 3, 0, "R3 store landed");

    // Random traffic
    pend[0] = 0; pend[1] = 0;
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < 2; i++) begin
        if (!pend[i] && ($urandom % 2 == 0)) begin
          pend[i] = 1;
          cop[i] = 2'($urandom);
          cad[i] = AW'($urandom);
          cwd[i] = DW'($urandom);
        end
        cv[i] = pend[i];
      end
      step("rand R3 R5 R6 R7");
      if (last_g >= 0) pend[last_g] = 0;
    end
    cv = '0;

    // R11: increment loop on word 3 from both requesters
    one(0, LD, 3, 0, "R11 start value");
    start = last_d;
    for (int i = 0; i < 2; i++) begin
      st[i] = 0; gap[i] = 0; cnt[i] = 0; sv[i] = '0; pend[i] = 0;
    end
    guard = 0;
    while ((st[0] != 2 || st[1] != 2) && guard < 20000) begin
      guard++;
      for (int i = 0; i < 2; i++) begin
        if (!pend[i]) begin
          if (st[i] == 2 || gap[i] > 0) begin
            if (gap[i] > 0) gap[i]--;
          end else begin
            pend[i] = 1;
            cad[i] = 3'd3;
            cop[i] = (st[i] == 0) ? LL : SC;
            cwd[i] = sv[i];
          end
        end
        cv[i] = pend[i];
      end
      step("R11 loop");
      if (last_g >= 0) begin
        if (cop[last_g] == LL) begin
          sv[last_g] = last_d + 1'b1;
          st[last_g] = 1;
        end else if (last_d[0]) begin
          cnt[last_g]++;
          st[last_g] = (cnt[last_g] == NINC) ? 2 : 0;
        end else begin
          st[last_g] = 0;
        end
        gap[last_g] = $urandom % 3;
        pend[last_g] = 0;
      end
    end
    cv = '0;
    chk("R11 loop finished", DW'(st[0] == 2 && st[1] == 2), DW'(1'b1));
    one(1, LD, 3, 0, "R11 final load");
    chk("R11 no lost increment", last_d, start + DW'(2 * NINC));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule